// File: doc/BRIEF.md
# Character Cell Video Serializer

This block turns one scan line of one character cell into a serial dot stream. When a new character starts, it takes a 7-bit dot pattern for the current scan line. For scan lines 0 to 7 the pattern comes from the primary glyph source. For scan lines 8 and 9 it comes from an extension source that serves the graphics characters. The block then applies the blanking rules for the display mode and the graphics option, and loads the result into a shift register. It sends the dots out most-significant first, one for each dot-clock enable. A low-intensity flag travels with the dots.

A character row is ten scan lines high. In the 1920-character mode, all ten lines can be lit when graphics is enabled. Without graphics, the two extension lines are dark. In the 960-character mode, only the first two lines of the row are shown and the other eight are dark. A graphics character that arrives while graphics is disabled does not show its glyph. On every line that is not blanked, it fills the whole cell at low intensity. The glyph contents themselves come from outside the block.

Top module: `cell_video_serializer`

## Requirements
- R1: While rst_ni is low, and after reset until the first load, video_o and dim_o are 0. Load strobes seen during reset have no effect.
- R2: A load of a normal character (gfx_char_i=0) on scan lines 0..7 of a shown line presents prim_dots_i. Bit 6 appears in the cycle after the load edge, and each later dot_en_i edge moves to the next lower bit. dim_o is 0.
- R3: In the 1920 mode (wide_i=1) with gfx_en_i=1, scan lines 8 and 9 present ext_dots_i in the same MSB-first order.
- R4: In the 1920 mode with gfx_en_i=0, scan lines 8 and 9 give video_o=0 and dim_o=0 for all seven dots.
- R5: In the 960 mode (wide_i=0), scan lines 2..9 give video_o=0 and dim_o=0 for all seven dots. Lines 0 and 1 are shown as on lines 0..7 of the 1920 mode.
- R6: A graphics character (gfx_char_i=1) with gfx_en_i=0 on a shown line gives video_o=1 and dim_o=1 on all seven dots.
- R7: A graphics character with gfx_en_i=1 is drawn from its source like a normal character, with dim_o=0.
- R8: Scan line values 10..15 give video_o=0 and dim_o=0 for all seven dots.
- R9: After seven dot enables following a load, video_o and dim_o stay 0 until the next load.
- R10: A load takes priority over a dot enable in the same cycle, and the new cell starts at bit 6. In a cycle with neither load_i nor dot_en_i, both outputs hold their values.
- R11: dim_o is 1 only while a filled low-intensity cell (R6) is being sent, and never while video_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start of a character cell: capture the pattern |
| dot_en_i | input | 1 | Dot clock enable: advance one dot |
| line_i | input | 4 | Scan line within the character row (0..9 valid) |
| wide_i | input | 1 | 1 = 1920-character mode, 0 = 960-character mode |
| gfx_en_i | input | 1 | Graphics option installed and enabled |
| gfx_char_i | input | 1 | Current character is a graphics symbol |
| prim_dots_i | input | 7 | Dot pattern from the primary source (lines 0..7) |
| ext_dots_i | input | 7 | Dot pattern from the extension source (lines 8..9) |
| video_o | output | 1 | Serial video dot |
| dim_o | output | 1 | Low-intensity flag for the current dot |

## Verification
The hardest case to reach is the interaction between blanking and the filled low-intensity cell. A graphics character with graphics disabled must light the cell on shown lines, yet stay dark on lines 8 and 9 and on the lines hidden in the 960 mode. The bench covers this with a full sweep over both modes, both option values, both character kinds and all sixteen line codes. In every cell it checks all seven dots and the idle dot that follows. Half of the cells start with a load in the same cycle as a dot enable, which exercises the load priority. The other half stall the shifter for several cycles after the load, which exercises the hold behaviour.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    LC_PRIM  = 2'd0,
    LC_EXT   = 2'd1,
    LC_BLANK = 2'd2
  } line_cls_e;
endpackage

// File: rtl/cvs_line_sel.sv
module cvs_line_sel #(
  parameter int DOTS         = 7,
  parameter int LINE_W       = 4,
  parameter int ROW_LINES    = 10,
  parameter int PRIM_LINES   = 8,
  parameter int NARROW_LINES = 2
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              wide_i,
  input  logic              gfx_en_i,
  input  logic              gfx_char_i,
  input  logic [DOTS-1:0]   prim_dots_i,
  input  logic [DOTS-1:0]   ext_dots_i,
  output logic [DOTS-1:0]   dots_o,
  output logic              dim_o
);
  import cvs_pkg::*;

  localparam logic [LINE_W-1:0] RowLim    = LINE_W'(ROW_LINES);
  localparam logic [LINE_W-1:0] PrimLim   = LINE_W'(PRIM_LINES);
  localparam logic [LINE_W-1:0] NarrowLim = LINE_W'(NARROW_LINES);

  line_cls_e cls;

  always_comb begin
    if (line_i >= RowLim)                     cls = LC_BLANK;
    else if (!wide_i && line_i >= NarrowLim)  cls = LC_BLANK;
    else if (line_i < PrimLim)                cls = LC_PRIM;
    else if (gfx_en_i)                        cls = LC_EXT;
    else                                      cls = LC_BLANK;
  end

  always_comb begin
    dots_o = '0;
    dim_o  = 1'b0;
    if (cls != LC_BLANK) begin
      if (gfx_char_i && !gfx_en_i) begin
        // graphics symbol without option: filled dim cell
        dots_o = '1;
        dim_o  = 1'b1;
      end else if (cls == LC_PRIM) begin
        dots_o = prim_dots_i;
      end else begin
        dots_o = ext_dots_i;
      end
    end
  end
endmodule

// File: rtl/cvs_shifter.sv
module cvs_shifter #(
  parameter int DOTS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic [DOTS-1:0] dots_i,
  input  logic            dim_i,
  output logic            video_o,
  output logic            dim_o
);
  localparam int CNT_W = $clog2(DOTS + 1);
  localparam logic [CNT_W-1:0] Full = CNT_W'(DOTS);

  logic [DOTS-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      dim_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= dots_i;
      cnt_q <= Full;
      dim_q <= dim_i;
    end else if (shift_i && cnt_q != '0) begin
      sh_q  <= {sh_q[DOTS-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign video_o = (cnt_q != '0) && sh_q[DOTS-1];
  assign dim_o   = (cnt_q != '0) && dim_q;
endmodule

// File: rtl/cell_video_serializer.sv
module cell_video_serializer #(
  parameter int DOTS         = 7,
  parameter int LINE_W       = 4,
  parameter int ROW_LINES    = 10,
  parameter int PRIM_LINES   = 8,
  parameter int NARROW_LINES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              dot_en_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wide_i,
  input  logic              gfx_en_i,
  input  logic              gfx_char_i,
  input  logic [DOTS-1:0]   prim_dots_i,
  input  logic [DOTS-1:0]   ext_dots_i,
  output logic              video_o,
  output logic              dim_o
);
  logic [DOTS-1:0] sel_dots;
  logic            sel_dim;

  cvs_line_sel #(
    .DOTS(DOTS), .LINE_W(LINE_W), .ROW_LINES(ROW_LINES),
    .PRIM_LINES(PRIM_LINES), .NARROW_LINES(NARROW_LINES)
  ) u_sel (
    .line_i      (line_i),
    .wide_i      (wide_i),
    .gfx_en_i    (gfx_en_i),
    .gfx_char_i  (gfx_char_i),
    .prim_dots_i (prim_dots_i),
    .ext_dots_i  (ext_dots_i),
    .dots_o      (sel_dots),
    .dim_o       (sel_dim)
  );

  cvs_shifter #(.DOTS(DOTS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .shift_i (dot_en_i),
    .dots_i  (sel_dots),
    .dim_i   (sel_dim),
    .video_o (video_o),
    .dim_o   (dim_o)
  );
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
  parameter int DOTS         = 7,
  parameter int LINE_W       = 4,
  parameter int ROW_LINES    = 10,
  parameter int PRIM_LINES   = 8,
  parameter int NARROW_LINES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              dot_en_i,
  input logic [LINE_W-1:0] line_i,
  input logic              wide_i,
  input logic              gfx_en_i,
  input logic              gfx_char_i,
  input logic              video_o,
  input logic              dim_o
);
  localparam int CNT_W = $clog2(DOTS + 1);
  localparam logic [LINE_W-1:0] RowLim    = LINE_W'(ROW_LINES);
  localparam logic [LINE_W-1:0] PrimLim   = LINE_W'(PRIM_LINES);
  localparam logic [LINE_W-1:0] NarrowLim = LINE_W'(NARROW_LINES);

  logic [CNT_W-1:0] left_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        left_q <= '0;
    else if (load_i)                    left_q <= CNT_W'(DOTS);
    else if (dot_en_i && left_q != '0)  left_q <= left_q - 1'b1;
  end

  a_r9_idle_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == '0) |-> (!video_o && !dim_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dot_en_i) |=> ($stable(video_o) && $stable(dim_o)));

  a_r11_dim_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_o |-> video_o);

  a_r4_ext_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && wide_i && !gfx_en_i && line_i >= PrimLim && line_i < RowLim)
      |=> (!video_o && !dim_o));

  a_r5_narrow_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wide_i && line_i >= NarrowLim) |=> (!video_o && !dim_o));

  a_r8_range_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && line_i >= RowLim) |=> (!video_o && !dim_o));

  a_r6_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && gfx_char_i && !gfx_en_i && line_i < NarrowLim) |=> (video_o && dim_o));
endmodule

bind cell_video_serializer cvs_checker #(
  .DOTS(DOTS), .LINE_W(LINE_W), .ROW_LINES(ROW_LINES),
  .PRIM_LINES(PRIM_LINES), .NARROW_LINES(NARROW_LINES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .dot_en_i(dot_en_i),
  .line_i(line_i), .wide_i(wide_i), .gfx_en_i(gfx_en_i),
  .gfx_char_i(gfx_char_i), .video_o(video_o), .dim_o(dim_o)
);

// File: tb/cell_video_serializer_tb_top.sv
`timescale 1ns/1ps
module cell_video_serializer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0, dot_en_i = 1'b0;
  logic [3:0] line_i = '0;
  logic       wide_i = 1'b0, gfx_en_i = 1'b0, gfx_char_i = 1'b0;
  logic [6:0] prim_dots_i = '0, ext_dots_i = '0;
  logic       video_o, dim_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  cell_video_serializer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .dot_en_i(dot_en_i),
    .line_i(line_i), .wide_i(wide_i), .gfx_en_i(gfx_en_i),
    .gfx_char_i(gfx_char_i), .prim_dots_i(prim_dots_i),
    .ext_dots_i(ext_dots_i), .video_o(video_o), .dim_o(dim_o)
  );

  task automatic chk(input string tag, input logic ev, input logic ed);
    checks++;
    if (video_o !== ev || dim_o !== ed) begin
      fails++;
      $display("FAIL %s video/dim actual=%b%b expected=%b%b (line=%0d wide=%b gen=%b gch=%b)",
               tag, video_o, dim_o, ev, ed, line_i, wide_i, gfx_en_i, gfx_char_i);
    end
  endtask

  // expected cell from the requirements
  function automatic logic [7:0] exp_cell(input logic w, input logic ge, input logic gc,
                                          input int ln, input logic [6:0] p, input logic [6:0] e);
    bit blank;
    blank = (ln >= 10) || (!w && ln >= 2) || (ln >= 8 && !ge);
    if (blank)        return 8'h00;
    if (gc && !ge)    return {7'h7F, 1'b1};
    if (ln < 8)       return {p, 1'b0};
    return {e, 1'b0};
  endfunction

  function automatic string tag_of(input logic w, input logic ge, input logic gc, input int ln);
    if (ln >= 10)         return "R8";
    if (!w && ln >= 2)    return "R5";
    if (ln >= 8)          return ge ? "R3" : "R4";
    if (gc && !ge)        return "R6 R11";
    if (gc)               return "R7 R11";
    return "R2 R11";
  endfunction

  task automatic run_cell(input logic w, input logic ge, input logic gc, input int ln,
                          input logic [6:0] p, input logic [6:0] e, input bit stall);
    logic [7:0] ex;
    string tg;
    ex = exp_cell(w, ge, gc, ln, p, e);
    tg = tag_of(w, ge, gc, ln);
    @(negedge clk_i);
    wide_i = w; gfx_en_i = ge; gfx_char_i = gc; line_i = 4'(ln);
    prim_dots_i = p; ext_dots_i = e;
    load_i = 1'b1;
    dot_en_i = stall ? 1'b0 : 1'b1; // R10: load wins over a concurrent dot enable
    @(posedge clk_i); @(negedge clk_i);
    load_i = 1'b0;
    // scramble inputs: captured pattern must not follow them
    prim_dots_i = ~p; ext_dots_i = ~e; gfx_char_i = ~gc;
    if (stall) begin
      dot_en_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk("R10 stall", ex[7], ex[0]);
        @(posedge clk_i); @(negedge clk_i);
      end
      dot_en_i = 1'b1;
    end
    for (int i = 6; i >= 0; i--) begin
      chk(tg, ex[i+1], ex[0]);
      @(posedge clk_i); @(negedge clk_i);
    end
    chk("R9 idle", 1'b0, 1'b0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R9 idle", 1'b0, 1'b0);
    dot_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: loads during reset ignored
    @(negedge clk_i);
    load_i = 1'b1; dot_en_i = 1'b1; prim_dots_i = 7'h7F; gfx_char_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 1'b0, 1'b0);
    load_i = 1'b0; dot_en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", 1'b0, 1'b0);

    for (int w = 0; w < 2; w++)
      for (int ge = 0; ge < 2; ge++)
        for (int gc = 0; gc < 2; gc++)
          for (int ln = 0; ln < 16; ln++)
            for (int s = 0; s < 2; s++) begin
              logic [6:0] p, e;
              p = 7'((ln * 37 + s * 83 + w * 11 + 5) % 128);
              e = 7'((ln * 53 + s * 29 + ge * 7 + 66) % 128);
              run_cell(w[0], ge[0], gc[0], ln, p, e, s[0]);
            end

    // edge patterns on primary and extension paths
    run_cell(1'b1, 1'b1, 1'b0, 0, 7'h7F, 7'h00, 1'b0);
    run_cell(1'b1, 1'b1, 1'b0, 9, 7'h00, 7'h7F, 1'b0);
    run_cell(1'b1, 1'b1, 1'b0, 8, 7'h7F, 7'h41, 1'b1);
    run_cell(1'b0, 1'b0, 1'b0, 1, 7'h01, 7'h7F, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule